// File: doc/BRIEF.md
# Pixel Output Blanking and Launch Stage

This block is the last digital stage between a 12-bit pixel converter model and the chip's output pins. Each data-clock cycle it takes one raw sample and the three line-timing strobes: optical-black clamp, dummy-pixel clamp and preblank. It turns every strobe into an active-high form using a programmable polarity. It builds a blank flag that only preblank can raise, and only when neither clamp strobe is active. The sample and its blank flag then pass together through a fixed pipeline of nine registers. A blanked word leaves the block as all zeros.

The final word can drive the output bus straight from the rising-edge pipeline. It can also be retimed onto the falling edge of the data clock. Either a configuration bit or a dedicated active-high disable pin releases the bus to high impedance. The two sampling clocks of the correlated double sampler go through their own polarity control. The block also forwards the front-end gain code, which is replaced by a fixed default whenever gain programming is disabled. All configuration inputs are static levels taken from a register file.

Top module: `pxo_output_stage`

## Requirements
- R1: With falling-edge launch off and the bus enabled, the word seen on `pix_out` after rising edge n is the sample present on `pix_in` at rising edge n-8. That is a latency of nine registers.
- R2: When preblank is active at the edge where a sample is taken, and neither clamp strobe is active, the word for that sample leaves as 12'h000.
- R3: When preblank is active together with the optical-black or the dummy clamp strobe, the clamp wins. The sample passes unchanged, and `ob_clamp_act` and `dm_clamp_act` follow their own strobes whatever preblank does.
- R4: `cfg_strobe_hi` sets the active level of the three line strobes and `cfg_smp_hi` sets it for the two sampling clocks (1 = active high, 0 = active low). The `*_act` outputs are always active high.
- R5: With `cfg_launch_fall` = 1, `pix_out` changes on the falling edge. In the first half of the cycle after rising edge n it shows the word that rising-edge launch showed after edge n-1.
- R6: If `cfg_out_hiz` = 1 or `out_disable` = 1 at a rising edge, `pix_out` is high impedance from that edge on. If both are 0 at a rising edge, the bus is driven from that edge on.
- R7: `gain_code_eff` equals `gain_code_reg` when `cfg_gain_en` = 1, and equals 63 when `cfg_gain_en` = 0.
- R8: At a rising edge with `rst_n` = 0, every pipeline stage and its blank flag is cleared and the bus is driven. For nine cycles after release the bus reads 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_in | input | 12 | Raw converter sample |
| ob_clamp_raw | input | 1 | Optical-black clamp strobe, programmable level |
| dm_clamp_raw | input | 1 | Dummy-pixel clamp strobe, programmable level |
| preblank_raw | input | 1 | Preblank strobe, programmable level |
| ref_smp_raw | input | 1 | Reference-level sampling clock |
| dat_smp_raw | input | 1 | Data-level sampling clock |
| cfg_strobe_hi | input | 1 | 1 = line strobes active high |
| cfg_smp_hi | input | 1 | 1 = sampling clocks active high |
| cfg_launch_fall | input | 1 | 1 = launch data on falling edge |
| cfg_out_hiz | input | 1 | 1 = release data bus |
| out_disable | input | 1 | Pin-level bus release, active high |
| cfg_gain_en | input | 1 | 1 = use programmed gain code |
| gain_code_reg | input | 6 | Programmed front-end gain code |
| ob_clamp_act | output | 1 | Optical-black clamp, active high |
| dm_clamp_act | output | 1 | Dummy clamp, active high |
| ref_smp_act | output | 1 | Reference sampling clock, active high |
| dat_smp_act | output | 1 | Data sampling clock, active high |
| gain_code_eff | output | 6 | Effective gain code |
| pix_out | output | 12 | Output data bus, tri-stated when released |

## Verification
Some properties are checked on every cycle by assertions. A blanked word reaching the end of the pipeline leaves the falling-edge register as zero. A release request takes the bus off on the next edge, and a clear request puts it back. Leaving reset finds the pipeline tail cleared and the bus driven. Other behaviour only shows up in the bench's scenarios, which compare the bus against a queue-based model on every cycle. These are the nine-cycle alignment of data and blank mask, clamp priority during overlaps, both polarity settings, the half-cycle shift of falling-edge launch, the gain override, and a reset in the middle of a line.

// File: rtl/pxo_pkg.sv
package pxo_pkg;

   typedef struct packed {
      logic ob;
      logic dm;
      logic pre;
   } line_strobes_t;

   function automatic logic to_active(input logic raw, input logic active_hi);
      return active_hi ? raw : ~raw;
   endfunction

endpackage

// File: rtl/pxo_strobe_decode.sv
module pxo_strobe_decode
   import pxo_pkg::*;
#(
   parameter int GAIN_W      = 6,
   parameter int GAIN_FORCED = 63
) (
   input  line_strobes_t     line_raw,
   input  logic              cfg_line_hi,
   input  logic              ref_raw,
   input  logic              dat_raw,
   input  logic              cfg_smp_hi,
   input  logic              gain_en,
   input  logic [GAIN_W-1:0] gain_reg,
   output line_strobes_t     line_act,
   output logic              ref_act,
   output logic              dat_act,
   output logic              blank,
   output logic [GAIN_W-1:0] gain_eff
);

   localparam logic [GAIN_W-1:0] FORCED_CODE = GAIN_W'(GAIN_FORCED);

   if (GAIN_FORCED < 0 || GAIN_FORCED >= (1 << GAIN_W)) begin : g_bad_gain
      $error("pxo_strobe_decode: GAIN_FORCED does not fit GAIN_W");
   end

   always_comb begin
      line_act.ob  = to_active(line_raw.ob,  cfg_line_hi);
      line_act.dm  = to_active(line_raw.dm,  cfg_line_hi);
      line_act.pre = to_active(line_raw.pre, cfg_line_hi);
      ref_act      = to_active(ref_raw, cfg_smp_hi);
      dat_act      = to_active(dat_raw, cfg_smp_hi);
   end

   // clamp strobes override preblank
   assign blank    = line_act.pre & ~(line_act.ob | line_act.dm);
   assign gain_eff = gain_en ? gain_reg : FORCED_CODE;

endmodule

// File: rtl/pxo_delay_line.sv
module pxo_delay_line #(
   parameter int WIDTH = 13,
   parameter int DEPTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pxo_delay_line: WIDTH must be positive");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [WIDTH-1:0] stage [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= stage[i-1];
            end
         end
      end

      assign dout = stage[DEPTH-1];
   end

endmodule

// File: rtl/pxo_launch.sv
module pxo_launch #(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] word_in,
   input  logic             blank_in,
   input  logic             fall_sel,
   input  logic             hiz_req,
   output logic [PIX_W-1:0] pix_out
);

   logic [PIX_W-1:0] masked;
   logic [PIX_W-1:0] neg_q;
   logic [PIX_W-1:0] launch_word;
   logic             oe_q;

   assign masked = blank_in ? '0 : word_in;

   always_ff @(negedge clk) begin
      if (!rst_n) neg_q <= '0;
      else        neg_q <= masked;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) oe_q <= 1'b1;
      else        oe_q <= ~hiz_req;
   end

   assign launch_word = fall_sel ? neg_q : masked;
   assign pix_out     = oe_q ? launch_word : {PIX_W{1'bz}};

   // R2: a blanked tail word leaves the falling-edge register as zero
   assert_blank_zero_R2 : assert property (@(negedge clk) disable iff (!rst_n)
      blank_in |=> (neg_q == '0));

   // R6: a release request takes the bus off at the next edge
   assert_hiz_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      hiz_req |=> !oe_q);

   // R6: a cleared request drives the bus again
   assert_hiz_drive_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !hiz_req |=> oe_q);

   // R8: leaving reset finds the pipeline tail cleared and the bus driven
   assert_reset_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (oe_q && word_in == '0 && !blank_in));

endmodule

// File: rtl/pxo_output_stage.sv
module pxo_output_stage
   import pxo_pkg::*;
#(
   parameter int PIX_W       = 12,
   parameter int LATENCY     = 9,
   parameter int GAIN_W      = 6,
   parameter int GAIN_FORCED = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix_in,
   input  logic              ob_clamp_raw,
   input  logic              dm_clamp_raw,
   input  logic              preblank_raw,
   input  logic              ref_smp_raw,
   input  logic              dat_smp_raw,
   input  logic              cfg_strobe_hi,
   input  logic              cfg_smp_hi,
   input  logic              cfg_launch_fall,
   input  logic              cfg_out_hiz,
   input  logic              out_disable,
   input  logic              cfg_gain_en,
   input  logic [GAIN_W-1:0] gain_code_reg,
   output logic              ob_clamp_act,
   output logic              dm_clamp_act,
   output logic              ref_smp_act,
   output logic              dat_smp_act,
   output logic [GAIN_W-1:0] gain_code_eff,
   output logic [PIX_W-1:0]  pix_out
);

   localparam int LANE_W = PIX_W + 1;

   if (LATENCY < 1) begin : g_bad_latency
      $error("pxo_output_stage: LATENCY must be at least one");
   end

   line_strobes_t    raw_s;
   line_strobes_t    act_s;
   logic             blank_now;
   logic [LANE_W-1:0] lane_head;
   logic [LANE_W-1:0] lane_tail;

   assign raw_s = '{ob: ob_clamp_raw, dm: dm_clamp_raw, pre: preblank_raw};

   pxo_strobe_decode #(
      .GAIN_W      (GAIN_W),
      .GAIN_FORCED (GAIN_FORCED)
   ) decode_i (
      .line_raw    (raw_s),
      .cfg_line_hi (cfg_strobe_hi),
      .ref_raw     (ref_smp_raw),
      .dat_raw     (dat_smp_raw),
      .cfg_smp_hi  (cfg_smp_hi),
      .gain_en     (cfg_gain_en),
      .gain_reg    (gain_code_reg),
      .line_act    (act_s),
      .ref_act     (ref_smp_act),
      .dat_act     (dat_smp_act),
      .blank       (blank_now),
      .gain_eff    (gain_code_eff)
   );

   assign ob_clamp_act = act_s.ob;
   assign dm_clamp_act = act_s.dm;
   assign lane_head    = {blank_now, pix_in};

   pxo_delay_line #(
      .WIDTH (LANE_W),
      .DEPTH (LATENCY)
   ) delay_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (lane_head),
      .dout  (lane_tail)
   );

   pxo_launch #(
      .PIX_W (PIX_W)
   ) launch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_in  (lane_tail[PIX_W-1:0]),
      .blank_in (lane_tail[PIX_W]),
      .fall_sel (cfg_launch_fall),
      .hiz_req  (cfg_out_hiz | out_disable),
      .pix_out  (pix_out)
   );

endmodule

// File: tb/pxo_output_stage_tb_top.sv
module pxo_output_stage_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pix_in = '0;
   logic        ob_raw = 1'b0, dm_raw = 1'b0, pre_raw = 1'b0;
   logic        ref_raw = 1'b0, dat_raw = 1'b0;
   logic        strobe_hi = 1'b1, smp_hi = 1'b1, launch_fall = 1'b0;
   logic        out_hiz = 1'b0, dis = 1'b0, gain_en = 1'b1;
   logic [5:0]  gain_reg = 6'd5;
   logic        ob_act, dm_act, ref_act, dat_act;
   logic [5:0]  gain_eff;
   logic [11:0] pix_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int word_h [0:4095];
   int kind_h [0:4095];   // 0 data, 1 blanked, 2 clamp overrode preblank
   bit rst_h  [0:4095];
   bit oe_h   [0:4095];

   always #10 clk = ~clk;

   pxo_output_stage dut_i (
      .clk(clk), .rst_n(rst_n), .pix_in(pix_in),
      .ob_clamp_raw(ob_raw), .dm_clamp_raw(dm_raw), .preblank_raw(pre_raw),
      .ref_smp_raw(ref_raw), .dat_smp_raw(dat_raw),
      .cfg_strobe_hi(strobe_hi), .cfg_smp_hi(smp_hi),
      .cfg_launch_fall(launch_fall), .cfg_out_hiz(out_hiz),
      .out_disable(dis), .cfg_gain_en(gain_en), .gain_code_reg(gain_reg),
      .ob_clamp_act(ob_act), .dm_clamp_act(dm_act),
      .ref_smp_act(ref_act), .dat_smp_act(dat_act),
      .gain_code_eff(gain_eff), .pix_out(pix_out)
   );

   function automatic bit lvl(input logic raw, input logic hi);
      return hi ? raw : !raw;
   endfunction

   // reference model: record what each rising edge captures
   always @(posedge clk) begin
      if (cyc < 4096) begin
         rst_h[cyc] = !rst_n;
         if (!rst_n) begin
            for (int j = 0; j < 9; j++) begin
               if (cyc - j >= 0) begin
                  word_h[cyc-j] = 0;
                  kind_h[cyc-j] = 0;
               end
            end
            oe_h[cyc] = 1'b1;
         end else begin
            automatic bit o = lvl(ob_raw, strobe_hi);
            automatic bit d = lvl(dm_raw, strobe_hi);
            automatic bit p = lvl(pre_raw, strobe_hi);
            if (p && !o && !d) begin
               word_h[cyc] = 0;
               kind_h[cyc] = 1;
            end else begin
               word_h[cyc] = int'(pix_in);
               kind_h[cyc] = (p && (o || d)) ? 2 : 0;
            end
            oe_h[cyc] = !(out_hiz || dis);
         end
      end
      cyc = cyc + 1;
   end

   function automatic int tail_at(input int n);
      return (n < 8) ? 0 : word_h[n-8];
   endfunction

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // sample at rising edge + 5 ns
   task automatic step();
      int n;
      logic [11:0] exp_w;
      string tag;
      @(posedge clk);
      #5;
      n = cyc - 1;
      if (launch_fall) exp_w = rst_h[n] ? 12'h000 : 12'(tail_at(n-1));
      else             exp_w = 12'(tail_at(n));
      if (!oe_h[n]) exp_w = 12'bz;
      if (rst_h[n])                  tag = "R8 reset";
      else if (!oe_h[n])             tag = "R6 tristate";
      else if (launch_fall)          tag = "R5 falling launch";
      else if (n >= 8 && kind_h[n-8] == 1) tag = "R2 blank";
      else if (n >= 8 && kind_h[n-8] == 2) tag = "R3 clamp priority";
      else                           tag = "R1 latency";
      chk(tag, pix_out, exp_w);
      chk("R4 ob strobe", {11'd0, ob_act}, {11'd0, lvl(ob_raw, strobe_hi)});
      chk("R3 dm strobe", {11'd0, dm_act}, {11'd0, lvl(dm_raw, strobe_hi)});
      chk("R4 sampling clocks", {10'd0, ref_act, dat_act},
          {10'd0, lvl(ref_raw, smp_hi), lvl(dat_raw, smp_hi)});
      chk("R7 gain", {6'd0, gain_eff}, {6'd0, gain_en ? gain_reg : 6'd63});
   endtask

   task automatic drive_random(input int strobe_pct, input bit force_overlap);
      bit o, d, p;
      pix_in   = 12'($urandom);
      o        = ($urandom % 100) < strobe_pct;
      d        = ($urandom % 100) < strobe_pct;
      p        = ($urandom % 100) < 40;
      if (force_overlap) begin
         p = 1'b1;
         if (!o && !d) o = 1'b1;
      end
      ob_raw   = strobe_hi ? o : !o;
      dm_raw   = strobe_hi ? d : !d;
      pre_raw  = strobe_hi ? p : !p;
      ref_raw  = 1'($urandom);
      dat_raw  = 1'($urandom);
      smp_hi   = 1'($urandom);
      gain_en  = 1'($urandom);
      gain_reg = 6'($urandom);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R8: reset holds bus driven and zero
      for (int i = 0; i < 12; i++) step();
      rst_n = 1'b1;
      // R1/R2: active-high strobes, rising launch
      for (int i = 0; i < 40; i++) begin drive_random(15, 1'b0); step(); end
      // R4: active-low strobes
      strobe_hi = 1'b0;
      for (int i = 0; i < 40; i++) begin drive_random(15, 1'b0); step(); end
      // R3: preblank overlapped by a clamp strobe
      strobe_hi = 1'b1;
      for (int i = 0; i < 20; i++) begin drive_random(30, 1'b1); step(); end
      for (int i = 0; i < 12; i++) begin drive_random(0, 1'b0); step(); end
      // R5: falling-edge launch
      launch_fall = 1'b1;
      for (int i = 0; i < 40; i++) begin drive_random(15, 1'b0); step(); end
      launch_fall = 1'b0;
      // R6: bus release by bit and by pin
      for (int i = 0; i < 40; i++) begin
         drive_random(15, 1'b0);
         out_hiz = (i % 7) < 2;
         dis     = (i % 5) == 3;
         step();
      end
      out_hiz = 1'b0;
      dis     = 1'b0;
      // R8: reset mid-line with a full pipeline, then refill
      for (int i = 0; i < 3; i++) begin drive_random(15, 1'b0); rst_n = 1'b0; step(); end
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) begin drive_random(15, 1'b0); step(); end
      launch_fall = 1'b1;
      for (int i = 0; i < 3; i++) begin drive_random(15, 1'b0); rst_n = 1'b0; step(); end
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) begin drive_random(15, 1'b0); step(); end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule